// File: doc/BRIEF.md
# Delayed Exponent Relinearization Stage

This stage undoes, in the digital data path, the gain that an external gain-ranging amplifier applied ahead of the converter. Each exponent step stands for 6.02 dB of external gain. The stage removes it by shifting the signed sample right by one bit per step. The result is widened so that no bit shifted out is lost.

The exponent comes from one of two places. One is a set of external exponent pins. The other is the internal gain-control code, which a separate gain decision block produces. An enable input picks the source. The internal code passes through a programmable alignment delay of 0 to 63 valid samples before it is used. This lets the attenuation change on the same sample where the external stage's gain change reaches the converter output, which can be 14 or more clocks after the code changes.

Top module: `relin_stage`

## Requirements
- R1: With exponent e (3 bits, 0 to 7), the output equals the input sample with 7 zero bits appended below it, arithmetically shifted right by e. The output is SAMPLE_W+7 bits wide and keeps the input's sign.
- R2: A sample accepted with `in_valid` high at a clock edge appears on `out_sample` with `out_valid` high after that edge. After an edge with `in_valid` low, `out_valid` is low and `out_sample` keeps its previous value.
- R3: After reset, `out_valid` and `out_sample` are 0, the exponent source is external, and every delay-line entry is 0.
- R4: The level of `use_internal` is captured with each valid sample and selects the source for the following valid samples: 1 selects the delayed internal code, 0 selects `ext_exp`. The source that is not selected has no effect on the output.
- R5: With `delay_sel` equal to 0 and the internal source selected, the `gain_code` present with the sample is applied to that same sample.
- R6: With `delay_sel` equal to d (1 to 63), the code applied is the `gain_code` that came with the valid sample d samples earlier, or 0 if fewer than d valid samples have arrived since reset. Delays of 14 and 63 are supported.
- R7: The delay line moves forward only on cycles with `in_valid` high. Idle cycles do not change which code is applied to later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a valid input sample |
| in_sample | input | SAMPLE_W | Signed converter sample |
| ext_exp | input | 3 | External exponent |
| gain_code | input | 3 | Internal gain-control code |
| use_internal | input | 1 | 1 selects the internal code, 0 selects the external exponent |
| delay_sel | input | 6 | Alignment delay for the internal code, in valid samples |
| out_valid | output | 1 | Marks a valid output sample |
| out_sample | output | SAMPLE_W+7 | Relinearized signed sample |

## Verification
The bench goes after the tap boundaries: delay 0, 1, 14 and 63, including the samples right after reset that must read zeros. A design with an off-by-one tap would apply each code one sample early or late. A design with a shift register that also moves on idle cycles would drift once gaps are placed between valid samples. The source switch is checked on the exact sample where it should take effect, and on the first sample after reset, so a design that selects the source combinationally would switch one sample too soon. Negative samples at the largest exponent catch a logical shift used in place of an arithmetic one, and a shift that drops the low bits.

// File: rtl/relin_pkg.sv
package relin_pkg;
    localparam int EXP_W     = 3;
    localparam int MAX_SHIFT = (1 << EXP_W) - 1;
    typedef logic [EXP_W-1:0] exp_t;
endpackage

// File: rtl/relin_delay_line.sv
module relin_delay_line
    import relin_pkg::*;
#(
    parameter int DELAY_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  exp_t               din,
    input  logic [DELAY_W-1:0] sel,
    output exp_t               tap
);
    localparam int DEPTH = (1 << DELAY_W) - 1;

    typedef struct packed {
        logic [DEPTH-1:0][EXP_W-1:0] line;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.line[0] = din;
        end
    end

    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       st_q.line[gi] <= '0;
            else if (advance) st_q.line[gi] <= st_q.line[gi-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.line[0] <= '0;
        else        st_q.line[0] <= st_d.line[0];
    end

    always_comb begin
        if (sel == '0) tap = din;
        else           tap = st_q.line[sel - 1'b1];
    end
endmodule

// File: rtl/relin_shift.sv
module relin_shift
    import relin_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int OUT_W   = SAMPLE_W + MAX_SHIFT
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  exp_t                expo,
    output logic [OUT_W-1:0]    result
);
    logic signed [OUT_W-1:0] widened;

    always_comb begin
        widened = $signed({sample, {MAX_SHIFT{1'b0}}});
        result  = widened >>> expo;
    end
endmodule

// File: rtl/relin_stage.sv
module relin_stage
    import relin_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 6,
    localparam int OUT_W   = SAMPLE_W + MAX_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [EXP_W-1:0]    ext_exp,
    input  logic [EXP_W-1:0]    gain_code,
    input  logic                use_internal,
    input  logic [DELAY_W-1:0]  delay_sel,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_sample
);
    typedef struct packed {
        logic             src_int;
        logic             vld;
        logic [OUT_W-1:0] data;
    } state_t;

    state_t           st_d, st_q;
    exp_t             tap_code;
    exp_t             expo_sel;
    logic [OUT_W-1:0] shifted;
    logic             src_int_q;

    relin_delay_line #(.DELAY_W(DELAY_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .din     (gain_code),
        .sel     (delay_sel),
        .tap     (tap_code)
    );

    relin_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .sample (in_sample),
        .expo   (expo_sel),
        .result (shifted)
    );

    always_comb begin
        expo_sel = st_q.src_int ? tap_code : ext_exp;
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data    = shifted;
            st_d.src_int = use_internal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_int_q  = st_q.src_int;
    assign out_valid  = st_q.vld;
    assign out_sample = st_q.data;
endmodule

// File: rtl/relin_checker.sv
module relin_checker
    import relin_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 6,
    localparam int OUT_W   = SAMPLE_W + MAX_SHIFT
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [EXP_W-1:0]    ext_exp,
    input logic [EXP_W-1:0]    gain_code,
    input logic [DELAY_W-1:0]  delay_sel,
    input logic                src_int_q,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_sample
);
    function automatic logic [OUT_W-1:0] scaled(input logic [SAMPLE_W-1:0] s, input exp_t e);
        logic signed [OUT_W-1:0] w;
        w = $signed({s, {MAX_SHIFT{1'b0}}});
        return w >>> e;
    endfunction

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample)));

    assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sample[OUT_W-1] == $past(in_sample[SAMPLE_W-1])));

    assert_ext_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !src_int_q) |=> (out_sample == scaled($past(in_sample), $past(ext_exp))));

    assert_zero_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_int_q && delay_sel == '0) |=>
            (out_sample == scaled($past(in_sample), $past(gain_code))));
endmodule

bind relin_stage relin_checker #(.SAMPLE_W(SAMPLE_W), .DELAY_W(DELAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .ext_exp    (ext_exp),
    .gain_code  (gain_code),
    .delay_sel  (delay_sel),
    .src_int_q  (src_int_q),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/sim_relin_stage.sv
`timescale 1ns/1ps
module sim_relin_stage;
    localparam int SW = 16;
    localparam int OW = SW + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [2:0]    ext_exp = '0;
    logic [2:0]    gain_code = '0;
    logic          use_internal = 1'b0;
    logic [5:0]    delay_sel = '0;
    logic          out_valid;
    logic [OW-1:0] out_sample;

    int checks = 0;
    int errors = 0;
    int n_seen = 0;
    logic       mode_m = 1'b0;
    logic [2:0] hist [0:1023];

    always #2 clk = ~clk;

    relin_stage #(.SAMPLE_W(SW), .DELAY_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ext_exp(ext_exp), .gain_code(gain_code), .use_internal(use_internal),
        .delay_sel(delay_sel), .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic logic [OW-1:0] expect_val(input logic [SW-1:0] s, input logic [2:0] e);
        logic signed [OW-1:0] w;
        w = $signed({s, 7'b0});
        return w >>> e;
    endfunction

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        use_internal = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        n_seen = 0;
        mode_m = 1'b0;
    endtask

    // drive one valid sample, then check the registered output one edge later
    task automatic send(input string req, input logic [SW-1:0] s, input logic [2:0] ee,
                        input logic [2:0] gc, input logic ui, input logic [5:0] d);
        logic [2:0] tapm, e;
        in_valid = 1'b1; in_sample = s; ext_exp = ee; gain_code = gc;
        use_internal = ui; delay_sel = d;
        if (d == 0)            tapm = gc;
        else if (n_seen >= d)  tapm = hist[n_seen - d];
        else                   tapm = 3'd0;
        e = mode_m ? tapm : ee;
        hist[n_seen] = gc;
        n_seen++;
        mode_m = ui;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {{(OW-1){1'b0}}, out_valid}, {{(OW-1){1'b0}}, 1'b1});
        check(req, out_sample, expect_val(s, e));
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R3 out_valid after reset", {{(OW-1){1'b0}}, out_valid}, '0);
        check("R3 out_sample after reset", out_sample, '0);
        // first sample after reset must use ext_exp even with use_internal high
        send("R3 external source after reset", 16'h4000, 3'd2, 3'd6, 1'b1, 6'd0);
    endtask

    task automatic t_external();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            send("R1 R4 external positive", 16'h1234 + 16'(i * 97), 3'(i), 3'(7 - i), 1'b0, 6'd5);
            send("R1 external negative", 16'h8001 + 16'(i * 3), 3'(i), 3'(i), 1'b0, 6'd0);
        end
        send("R1 most negative by 7", 16'h8000, 3'd7, 3'd0, 1'b0, 6'd0);
        send("R1 minus one by 7", 16'hFFFF, 3'd7, 3'd0, 1'b0, 6'd0);
    endtask

    task automatic t_switch();
        do_reset();
        send("R4 still external", 16'h0F00, 3'd1, 3'd4, 1'b1, 6'd0);
        send("R4 now internal", 16'h0F00, 3'd1, 3'd4, 1'b0, 6'd0);
        send("R4 external again", 16'h0F00, 3'd1, 3'd4, 1'b0, 6'd0);
    endtask

    task automatic t_zero_delay();
        do_reset();
        send("R5 arm", 16'h7FFF, 3'd0, 3'd0, 1'b1, 6'd0);
        for (int i = 0; i < 8; i++)
            send("R5 zero delay", 16'hC35A ^ 16'(i * 1111), 3'(7 - i), 3'(i), 1'b1, 6'd0);
    endtask

    task automatic t_delay(input logic [5:0] d, input int count);
        do_reset();
        send("R6 arm", 16'h2000, 3'd0, 3'd3, 1'b1, d);
        for (int i = 0; i < count; i++)
            send("R6 delayed code", 16'h9ABC + 16'(i * 257), 3'd7, 3'((i * 5 + 1) % 8), 1'b1, d);
    endtask

    task automatic t_gaps();
        logic [OW-1:0] held;
        do_reset();
        send("R7 arm", 16'h1111, 3'd0, 3'd2, 1'b1, 6'd3);
        for (int i = 0; i < 10; i++) begin
            send("R7 delayed across gaps", 16'h5555 - 16'(i * 31), 3'd0, 3'((i + 3) % 8), 1'b1, 6'd3);
            held = out_sample;
            gain_code = 3'(7 - i % 8);
            in_sample = 16'hFFFF;
            repeat (i % 3 + 1) @(negedge clk);
            check("R2 idle out_valid low", {{(OW-1){1'b0}}, out_valid}, '0);
            check("R2 idle output held", out_sample, held);
        end
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_external();
                t_switch();
                t_zero_delay();
                t_delay(6'd1, 6);
                t_delay(6'd14, 30);
                t_delay(6'd63, 80);
                t_gaps();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule